// File: doc/BRIEF.md
# Programmable Product-Term AND Plane

This block is the AND plane of a small programmable logic array. Sixteen logic signals enter it. Each one is split into a true column and an inverted column, which gives thirty-two columns. Sixty-four product-term rows each hold a thirty-two bit connection mask. A row's output is the AND of every column whose mask bit is set. Because both polarities of every signal are available, each term chooses its own input polarity.

The rows are grouped eight at a time. A fixed OR gate per group forms one sum-of-products result for each of the eight output cells that follow. The masks are loaded through a one-bit serial configuration port before use. While that port is shifting, every term is held inactive. Once loading stops, evaluation is purely combinational from the signal inputs.

Top module: `pterm_array`

## Requirements
- R1: After reset every mask bit is 1. With every term connected to both polarities of every signal, all term outputs and all group outputs are 0 for any input.
- R2: Each cycle with `cfg_shift_en` high moves the mask chain by one bit. A full load of 2048 bits fills row 63 first and row 0 last. Within each row the column-31 bit comes first and the column-0 bit comes last.
- R3: With `cfg_shift_en` low, the mask contents do not change, whatever `cfg_shift_in` does.
- R4: Column 2i carries `sig_in[i]` and column 2i+1 carries its inverse. `term_out[r]` is 1 exactly when every column selected by row r's mask is 1.
- R5: A row whose mask is all zeros drives 1 for every input pattern.
- R6: A row whose mask selects both columns of the same signal drives 0 for every input pattern.
- R7: While `cfg_shift_en` is high, all term outputs and group outputs are 0.
- R8: `grp_out[g]` is the OR of `term_out[8g]` through `term_out[8g+7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets all mask bits |
| cfg_shift_en | input | 1 | Shift one mask bit per cycle; holds terms inactive |
| cfg_shift_in | input | 1 | Serial mask data |
| sig_in | input | 16 | Logic signals feeding the plane |
| term_out | output | 64 | Product-term results, one per row |
| grp_out | output | 8 | OR of each group of eight rows |

## Verification
The only internal state is the mask chain. A bit that lands in the wrong place, or a bit that is lost, shows up as a wrong term on the very next input pattern after loading ends. A directed load therefore places one literal in the first row shifted and checks that only that row reacts. Random masks are then loaded, mixing empty rows, complementary-pair rows and sparse literal rows. Every row and group is compared with a model after each input pattern. This covers polarity swaps, chain misordering and stray updates while the port is idle.

// File: rtl/pterm_array.sv
module pterm_array #(
  parameter int N_SIG        = 16,
  parameter int N_ROW        = 64,
  parameter int ROWS_PER_GRP = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_shift_en,
  input  logic                          cfg_shift_in,
  input  logic [N_SIG-1:0]              sig_in,
  output logic [N_ROW-1:0]              term_out,
  output logic [N_ROW/ROWS_PER_GRP-1:0] grp_out
);
  localparam int N_COL  = 2 * N_SIG;
  localparam int N_BITS = N_COL * N_ROW;
  localparam int N_GRP  = N_ROW / ROWS_PER_GRP;

  logic [N_BITS-1:0] cfg_q;
  logic [N_COL-1:0]  col;

  for (genvar i = 0; i < N_SIG; i++) begin : g_buf
    assign col[2*i]   = sig_in[i];
    assign col[2*i+1] = ~sig_in[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cfg_q <= '1;
    else if (cfg_shift_en) cfg_q <= {cfg_q[N_BITS-2:0], cfg_shift_in};

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    logic [N_COL-1:0] mask;
    logic [N_SIG-1:0] pair_hit;
    assign mask = cfg_q[r*N_COL +: N_COL];
    assign term_out[r] = ~cfg_shift_en & (&(col | ~mask));

    for (genvar i = 0; i < N_SIG; i++) begin : g_pair
      assign pair_hit[i] = mask[2*i] & mask[2*i+1];
    end

    AST_EMPTY_ROW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_shift_en && mask == '0) |-> term_out[r]);  // R5
    AST_PAIR_ROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (|pair_hit) |-> !term_out[r]);  // R6
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_out[g] = |term_out[g*ROWS_PER_GRP +: ROWS_PER_GRP];
  end

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift_en |=> $stable(cfg_q));  // R3
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift_en |=> cfg_q[0] == $past(cfg_shift_in));  // R2
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift_en |=> cfg_q[N_BITS-1:1] == $past(cfg_q[N_BITS-2:0]));  // R2
  AST_SHIFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift_en |-> (grp_out == '0));  // R7
endmodule

// File: tb/pterm_array_tb.sv
module pterm_array_tb;
  localparam int NS = 16, NR = 64, NG = 8, NC = 32;

  logic clk = 1'b0, rst_n = 1'b0, sh_en = 1'b0, sh_in = 1'b0;
  logic [NS-1:0] sig = '0;
  logic [NR-1:0] term;
  logic [NG-1:0] grp;
  always #2.5 clk = ~clk;

  pterm_array u_dut (.clk(clk), .rst_n(rst_n), .cfg_shift_en(sh_en), .cfg_shift_in(sh_in),
                     .sig_in(sig), .term_out(term), .grp_out(grp));

  typedef struct { logic [NR-1:0] t; logic [NG-1:0] g; string req; } exp_t;
  exp_t q[$];
  logic [NC-1:0] mdl [NR];
  int n_chk = 0, n_fail = 0;

  function automatic logic [NR-1:0] model_terms(logic [NS-1:0] s);
    logic [NR-1:0] t;
    for (int r = 0; r < NR; r++) begin
      t[r] = 1'b1;
      for (int i = 0; i < NS; i++) begin
        if (mdl[r][2*i] && !s[i]) t[r] = 1'b0;
        if (mdl[r][2*i+1] && s[i]) t[r] = 1'b0;
      end
    end
    return t;
  endfunction

  function automatic logic [NG-1:0] model_grp(logic [NR-1:0] t);
    logic [NG-1:0] g;
    for (int k = 0; k < NG; k++) g[k] = |t[k*8 +: 8];
    return g;
  endfunction

  task automatic push(logic [NR-1:0] t, string req);
    exp_t e;
    e.t = t; e.g = model_grp(t); e.req = req;
    q.push_back(e);
  endtask

  task automatic drive(logic [NS-1:0] s, string req);
    @(negedge clk);
    sig = s;
    push(model_terms(s), req);
  endtask

  task automatic load();
    for (int r = NR - 1; r >= 0; r--)
      for (int c = NC - 1; c >= 0; c--) begin
        @(negedge clk);
        sh_en = 1'b1;
        sh_in = mdl[r][c];
        if (r == 40 && c == 7) begin
          sig = 16'h5A5A;
          push('0, "R7");
        end
      end
    @(negedge clk);
    sh_en = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (term !== e.t) begin
          n_fail++;
          $display("FAIL %s term_out act=%h exp=%h", e.req, term, e.t);
        end
        n_chk++;
        if (grp !== e.g) begin
          n_fail++;
          $display("FAIL R8 (%s) grp_out act=%h exp=%h", e.req, grp, e.g);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    logic [NS-1:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state leaves every term and group low
    for (int r = 0; r < NR; r++) mdl[r] = '1;
    drive('0, "R1");
    drive('1, "R1");
    drive(16'hA5C3, "R1");

    // R2: one literal (complement of sig 15, column 31) in the first row shifted; other rows empty
    for (int r = 0; r < NR; r++) mdl[r] = '0;
    mdl[63] = 32'h8000_0000;
    load();
    drive(16'h8000, "R2");
    drive(16'h7FFF, "R2");

    // Random masks: empty rows, pair rows, sparse literal rows
    for (int r = 0; r < NR; r++) begin
      logic [NC-1:0] m;
      m = '0;
      case (r % 4)
        0: m = '0;
        1: begin
          int i;
          i = int'($urandom_range(NS - 1));
          m[2*i] = 1'b1; m[2*i+1] = 1'b1;
          m[2*int'($urandom_range(NS - 1))] = 1'b1;
        end
        default: begin
          int k;
          k = 1 + int'($urandom_range(2));
          for (int j = 0; j < k; j++) begin
            int i;
            i = int'($urandom_range(NS - 1));
            if (!m[2*i] && !m[2*i+1]) m[2*i + int'($urandom_range(1))] = 1'b1;
          end
        end
      endcase
      mdl[r] = m;
    end
    load();
    drive('0, "R4");
    drive('1, "R4");
    drive(16'h0001, "R5");
    drive(16'hFFFE, "R6");
    for (int n = 0; n < 200; n++) begin
      pat = 16'($urandom);
      drive(pat, "R4");
    end

    // R3: the serial input toggles while the port is idle; the masks must stay put
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      sh_in = n[0];
    end
    for (int n = 0; n < 50; n++) begin
      pat = 16'($urandom);
      drive(pat, "R3");
    end

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule